// File: doc/BRIEF.md
# Reversible Two's-Complement Adder/Subtractor

This block adds or subtracts two N-bit operands using a network made only of bijective gates: controlled-NOT, Peres and Toffoli. Each is written as its own small module. One control line selects the operation, 0 for add and 1 for subtract. Subtraction is done as X plus the inverted Y plus one. Every gate keeps all of its input information on its outputs, so the whole network has exactly as many output lines as input lines.

The control line is never fanned out. Each bit stage passes a copy of it onto an output line, and the next stage takes its control from that line. The carry into bit zero is not an external input. A controlled-NOT writes the control value onto a zero-valued spare line, which gives 0 for add and 1 for subtract. Signed overflow is formed by two controlled-NOTs on a second spare line: one copies the carry entering the top bit, and the other XORs in the carry leaving it. For unsigned operands, the final carry is the overflow indicator. The spare lines must be tied to 0 for the arithmetic outputs to hold their meaning. With any other value on them, the circuit still maps inputs to outputs one-to-one.

Top module: `rev_addsub`

## Requirements
- R1: With all spare lines 0 and `op_sub_i`=0, `res_o` equals (`x_i` + `y_i`) mod 2^N.
- R2: With all spare lines 0 and `op_sub_i`=1, `res_o` equals (`x_i` − `y_i`) mod 2^N.
- R3: With all spare lines 0, `carry_o` is the unsigned carry out of `x_i`+`y_i` when adding. When subtracting, it is 1 exactly when `x_i` ≥ `y_i` as unsigned values, so equal operands give 1.
- R4: With all spare lines 0, `ovf_o` is 1 exactly when the true signed result of the selected operation lies outside [−2^(N−1), 2^(N−1)−1].
- R5: For any input, `op_o` equals `op_sub_i`, `gx_o` equals `x_i`, and `gp_o` equals `x_i` ^ `y_i` ^ {N{`op_sub_i`}}.
- R6: The map from the 3N+3 input lines to the 3N+3 output lines is a bijection. Bit i of `sp_bit_i` is recovered as cout_i ^ (gp_i & cin_i) ^ (x_i & (y_i ^ op)). Here cin_i = res_i ^ gp_i, and cout_i is cin_(i+1) for bits below the top and `carry_o` for the top bit. `sp_cin_i` is recovered as cin_0 ^ op, and `sp_ovf_i` as `ovf_o` ^ cin_(N−1) ^ `carry_o`.
- R7: Both Peres gate variants, native and Toffoli followed by controlled-NOT, give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| x_i | input | N | First operand |
| y_i | input | N | Second operand |
| sp_bit_i | input | N | Per-stage spare lines, tie to 0 |
| sp_cin_i | input | 1 | Spare line that becomes the bit-zero carry, tie to 0 |
| sp_ovf_i | input | 1 | Spare line that becomes the overflow flag, tie to 0 |
| op_o | output | 1 | Control copy forwarded from the top stage |
| gx_o | output | N | Garbage: copy of each X bit |
| gp_o | output | N | Garbage: X ^ Y ^ op per bit |
| res_o | output | N | Sum or difference |
| carry_o | output | 1 | Carry out of the top stage |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The arithmetic assertions (R1 to R4) take for granted that every spare line is driven to 0. Each of them is guarded by that condition, so a nonzero spare line makes them vacuous rather than failing. The R5 assertion does not depend on the spare lines and holds for all inputs. For N=4 the stimulus sweeps all 2^15 combinations of operands, operation and spare lines. The arithmetic results are compared only on the zero-spare subset, while the inverse reconstruction of R6 is checked on every vector. A second instance with the split Peres variant is compared line-for-line with the first.

// File: rtl/rev_pkg.sv
package rev_pkg;
   typedef enum logic {
      PERES_NATIVE = 1'b0,
      PERES_SPLIT  = 1'b1
   } peres_style_e;
endpackage

// File: rtl/rev_cnot.sv
module rev_cnot (
   input  logic ctl_i,
   input  logic tgt_i,
   output logic ctl_o,
   output logic tgt_o
);
   assign ctl_o = ctl_i;
   assign tgt_o = tgt_i ^ ctl_i;
endmodule

// File: rtl/rev_toffoli.sv
module rev_toffoli (
   input  logic a_i,
   input  logic b_i,
   input  logic t_i,
   output logic a_o,
   output logic b_o,
   output logic t_o
);
   assign a_o = a_i;
   assign b_o = b_i;
   assign t_o = t_i ^ (a_i & b_i);
endmodule

// File: rtl/rev_peres.sv
module rev_peres
   import rev_pkg::*;
#(
   parameter peres_style_e STYLE = PERES_NATIVE
) (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic p_o,
   output logic q_o,
   output logic r_o
);
   generate
      if (STYLE == PERES_NATIVE) begin : g_native
         assign p_o = a_i;
         assign q_o = a_i ^ b_i;
         assign r_o = (a_i & b_i) ^ c_i;
      end else begin : g_split
         logic ta, tb;
         rev_toffoli u_tof (
            .a_i (a_i), .b_i (b_i), .t_i (c_i),
            .a_o (ta),  .b_o (tb),  .t_o (r_o)
         );
         rev_cnot u_cx (
            .ctl_i (ta), .tgt_i (tb),
            .ctl_o (p_o), .tgt_o (q_o)
         );
      end
   endgenerate
endmodule

// File: rtl/rev_cas_stage.sv
module rev_cas_stage
   import rev_pkg::*;
#(
   parameter peres_style_e STYLE = PERES_NATIVE
) (
   input  logic op_i,
   input  logic x_i,
   input  logic y_i,
   input  logic cin_i,
   input  logic sp_i,
   output logic op_o,
   output logic gx_o,
   output logic gp_o,
   output logic s_o,
   output logic cout_o
);
   logic y_eff;
   logic prop;
   logic gen;

   // conditional inversion of Y by the operation line
   rev_cnot u_inv (
      .ctl_i (op_i), .tgt_i (y_i),
      .ctl_o (op_o), .tgt_o (y_eff)
   );

   // first half adder: propagate and generate, generate lands on the spare line
   rev_peres #(.STYLE(STYLE)) u_ha0 (
      .a_i (x_i),  .b_i (y_eff), .c_i (sp_i),
      .p_o (gx_o), .q_o (prop),  .r_o (gen)
   );

   // second half adder: sum and carry out
   rev_peres #(.STYLE(STYLE)) u_ha1 (
      .a_i (prop), .b_i (cin_i), .c_i (gen),
      .p_o (gp_o), .q_o (s_o),   .r_o (cout_o)
   );
endmodule

// File: rtl/rev_addsub.sv
module rev_addsub
   import rev_pkg::*;
#(
   parameter int           N     = 8,
   parameter peres_style_e STYLE = PERES_NATIVE
) (
   input  logic         op_sub_i,
   input  logic [N-1:0] x_i,
   input  logic [N-1:0] y_i,
   input  logic [N-1:0] sp_bit_i,
   input  logic         sp_cin_i,
   input  logic         sp_ovf_i,
   output logic         op_o,
   output logic [N-1:0] gx_o,
   output logic [N-1:0] gp_o,
   output logic [N-1:0] res_o,
   output logic         carry_o,
   output logic         ovf_o
);
   localparam int TOP = N - 1;

   generate
      if (N < 2) begin : g_bad_width
         $error("rev_addsub: N must be at least 2");
      end
   endgenerate

   logic [N:0] op_chain;
   logic [N:0] c_chain;
   logic       c_top_in;
   logic       ovf_mid;

   // bit-zero carry: control written onto a zero spare line
   rev_cnot u_cin (
      .ctl_i (op_sub_i), .tgt_i (sp_cin_i),
      .ctl_o (op_chain[0]), .tgt_o (c_chain[0])
   );

   // copy of the carry entering the top stage
   rev_cnot u_ovf_copy (
      .ctl_i (c_chain[TOP]), .tgt_i (sp_ovf_i),
      .ctl_o (c_top_in),     .tgt_o (ovf_mid)
   );

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_stage
         logic cin_s;
         if (i == TOP) begin : g_top_cin
            assign cin_s = c_top_in;
         end else begin : g_mid_cin
            assign cin_s = c_chain[i];
         end
         rev_cas_stage #(.STYLE(STYLE)) u_st (
            .op_i   (op_chain[i]),
            .x_i    (x_i[i]),
            .y_i    (y_i[i]),
            .cin_i  (cin_s),
            .sp_i   (sp_bit_i[i]),
            .op_o   (op_chain[i+1]),
            .gx_o   (gx_o[i]),
            .gp_o   (gp_o[i]),
            .s_o    (res_o[i]),
            .cout_o (c_chain[i+1])
         );
      end
   endgenerate

   // fold the carry out of the top stage into the copied carry-in
   rev_cnot u_ovf_fold (
      .ctl_i (c_chain[N]), .tgt_i (ovf_mid),
      .ctl_o (carry_o),    .tgt_o (ovf_o)
   );

   assign op_o = op_chain[N];
endmodule

// File: rtl/rev_addsub_chk.sv
module rev_addsub_chk #(
   parameter int N = 8
) (
   input logic         op_sub_i,
   input logic [N-1:0] x_i,
   input logic [N-1:0] y_i,
   input logic [N-1:0] sp_bit_i,
   input logic         sp_cin_i,
   input logic         sp_ovf_i,
   input logic         op_o,
   input logic [N-1:0] gx_o,
   input logic [N-1:0] gp_o,
   input logic [N-1:0] res_o,
   input logic         carry_o,
   input logic         ovf_o
);
   logic         known;
   logic         spare_zero;
   logic [N:0]   uadd;
   logic [N:0]   wide;

   always_comb begin
      known      = !$isunknown({op_sub_i, x_i, y_i, sp_bit_i, sp_cin_i, sp_ovf_i,
                                op_o, gx_o, gp_o, res_o, carry_o, ovf_o});
      spare_zero = (sp_bit_i == '0) && !sp_cin_i && !sp_ovf_i;
      uadd       = {1'b0, x_i} + {1'b0, y_i};
      wide       = op_sub_i ? ({x_i[N-1], x_i} - {y_i[N-1], y_i})
                            : ({x_i[N-1], x_i} + {y_i[N-1], y_i});
   end

   always_comb begin
      if (known && spare_zero) begin
         // R1
         add_sum_chk: assert (op_sub_i || res_o == uadd[N-1:0])
            else $error("add result mismatch");
         // R2
         sub_sum_chk: assert (!op_sub_i || res_o == x_i - y_i)
            else $error("sub result mismatch");
         // R3
         carry_out_chk: assert (carry_o == (op_sub_i ? (x_i >= y_i) : uadd[N]))
            else $error("carry mismatch");
         // R4
         no_overflow_chk: assert (ovf_o == (wide[N] ^ wide[N-1]))
            else $error("overflow flag mismatch");
      end
      if (known) begin
         // R5
         garbage_lines_chk: assert (op_o == op_sub_i && gx_o == x_i &&
                                    gp_o == (x_i ^ y_i ^ {N{op_sub_i}}))
            else $error("forwarded lines mismatch");
      end
   end
endmodule

bind rev_addsub rev_addsub_chk #(.N(N)) u_chk (
   .op_sub_i (op_sub_i), .x_i (x_i), .y_i (y_i),
   .sp_bit_i (sp_bit_i), .sp_cin_i (sp_cin_i), .sp_ovf_i (sp_ovf_i),
   .op_o (op_o), .gx_o (gx_o), .gp_o (gp_o), .res_o (res_o),
   .carry_o (carry_o), .ovf_o (ovf_o)
);

// File: tb/rev_addsub_test.sv
module rev_addsub_test;
   import rev_pkg::*;

   localparam int N  = 4;
   localparam int NV = 1 << (3*N + 3);

   typedef struct {
      logic         op;
      logic [N-1:0] x;
      logic [N-1:0] y;
      logic [N-1:0] sb;
      logic         sc;
      logic         so;
   } item_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         op_sub, sp_cin, sp_ovf;
   logic [N-1:0] x, y, sp_bit;
   logic         op_a, carry_a, ovf_a, op_b, carry_b, ovf_b;
   logic [N-1:0] gx_a, gp_a, res_a, gx_b, gp_b, res_b;

   rev_addsub #(.N(N), .STYLE(PERES_NATIVE)) uut (
      .op_sub_i (op_sub), .x_i (x), .y_i (y),
      .sp_bit_i (sp_bit), .sp_cin_i (sp_cin), .sp_ovf_i (sp_ovf),
      .op_o (op_a), .gx_o (gx_a), .gp_o (gp_a), .res_o (res_a),
      .carry_o (carry_a), .ovf_o (ovf_a)
   );

   rev_addsub #(.N(N), .STYLE(PERES_SPLIT)) uut_split (
      .op_sub_i (op_sub), .x_i (x), .y_i (y),
      .sp_bit_i (sp_bit), .sp_cin_i (sp_cin), .sp_ovf_i (sp_ovf),
      .op_o (op_b), .gx_o (gx_b), .gp_o (gp_b), .res_o (res_b),
      .carry_o (carry_b), .ovf_o (ovf_b)
   );

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;
   item_t sb_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (op=%0b x=%0h y=%0h)",
                  req, act, exp, op_sub, x, y);
      end
   endtask

   task automatic drive(input int v);
      item_t it;
      @(negedge clk);
      it.x  = v[N-1:0];
      it.y  = v[2*N-1:N];
      it.op = v[2*N];
      it.sb = v[3*N:2*N+1];
      it.sc = v[3*N+1];
      it.so = v[3*N+2];
      x = it.x; y = it.y; op_sub = it.op;
      sp_bit = it.sb; sp_cin = it.sc; sp_ovf = it.so;
      sb_q.push_back(it);
   endtask

   // monitor: pop one expected item per rising edge and compare
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         item_t        it;
         logic [N:0]   uadd;
         logic [N-1:0] eres;
         logic         ecarry, eovf;
         int           sx, sy, sr;
         logic [N:0]   cin_r;
         logic [N-1:0] sb_r;
         logic         sc_r, so_r;
         it = sb_q.pop_front();

         // R5 forwarded control and garbage lines, any spare value
         chk(op_a == it.op, "R5 op_o", int'(op_a), int'(it.op));
         chk(gx_a == it.x, "R5 gx_o", int'(gx_a), int'(it.x));
         chk(gp_a == (it.x ^ it.y ^ {N{it.op}}), "R5 gp_o",
             int'(gp_a), int'(it.x ^ it.y ^ {N{it.op}}));

         // R6 inverse reconstruction of the spare lines
         for (int i = 0; i < N; i++) cin_r[i] = res_a[i] ^ gp_a[i];
         cin_r[N] = carry_a;
         for (int i = 0; i < N; i++)
            sb_r[i] = cin_r[i+1] ^ (gp_a[i] & cin_r[i]) ^ (gx_a[i] & (((gp_a[i] ^ gx_a[i]) ^ op_a) ^ op_a));
         sc_r = cin_r[0] ^ op_a;
         so_r = ovf_a ^ cin_r[N-1] ^ carry_a;
         chk({sb_r, sc_r, so_r} == {it.sb, it.sc, it.so}, "R6 inverse",
             int'({sb_r, sc_r, so_r}), int'({it.sb, it.sc, it.so}));

         // R7 split Peres variant matches native
         chk({op_b, gx_b, gp_b, res_b, carry_b, ovf_b} ==
             {op_a, gx_a, gp_a, res_a, carry_a, ovf_a}, "R7 variants",
             int'({res_b, carry_b, ovf_b}), int'({res_a, carry_a, ovf_a}));

         if (it.sb == '0 && !it.sc && !it.so) begin
            uadd = {1'b0, it.x} + {1'b0, it.y};
            sx = int'($signed(it.x));
            sy = int'($signed(it.y));
            if (!it.op) begin
               eres = uadd[N-1:0]; ecarry = uadd[N]; sr = sx + sy;
               chk(res_a == eres, "R1 sum", int'(res_a), int'(eres));
            end else begin
               eres = it.x - it.y; ecarry = (it.x >= it.y); sr = sx - sy;
               chk(res_a == eres, "R2 difference", int'(res_a), int'(eres));
            end
            chk(carry_a == ecarry, "R3 carry", int'(carry_a), int'(ecarry));
            eovf = (sr > (1 << (N-1)) - 1) || (sr < -(1 << (N-1)));
            chk(ovf_a == eovf, "R4 overflow", int'(ovf_a), int'(eovf));
         end
      end
   end

   initial begin
      x = '0; y = '0; op_sub = 1'b0; sp_bit = '0; sp_cin = 1'b0; sp_ovf = 1'b0;
      for (int v = 0; v < NV; v++) drive(v);
      @(posedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", sb_q.size(), 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule